// File: doc/BRIEF.md
# Transceiver Sleep and Transmit-Trigger Control

This block is the control-register unit that sits in front of a radio transceiver state machine. Software writes a small control register that holds two bits. The first is a self-clearing reset request for the transceiver sequencer alone. The second is a multi-purpose level bit that software sets and clears, and that hardware never changes. The effect of the level bit depends on the state the sequencer is in when the bit changes. In the two transmit-ready states, a 0-to-1 change launches a transmission and emits a single-cycle start pulse. In the off state, a high level puts the transceiver to sleep and clearing the bit wakes it. In the two receive states, a high level parks the transceiver in a paused state until the bit is cleared, and it then returns to the receive state it came from.

A separate command port moves the sequencer between its steady states, in the way a normal state-change register would. A `tx_done` input ends a transmission. The state, the two start pulses and a reset strobe are registered outputs. They change on the clock edge that samples the write or the command.

Top module: `trxc_ctrl`

## Requirements
- R1: While `rst_n` is low, and after it is released, `state_o` is 0 (off), all pulse outputs are 0, and `rdata` is 0. State codes are: 0 off, 1 tx-ready, 2 listen, 3 listen-with-ack, 4 tx-ready-retry, 5 doze, 6 sending, 7 paused.
- R2: A write with bit 0 set raises `trx_reset_o` for exactly the one cycle after that edge. Bit 0 always reads back as 0 in `rdata`.
- R3: Bit 1 of the register takes the written value on every write and holds it until the next write. It reads back in `rdata[1]`.
- R4: In state 1, a write that changes bit 1 from 0 to 1 gives a one-cycle `tx_start_o` and state 6. A later `tx_done` returns the state to 1.
- R5: In state 4, a write that changes bit 1 from 0 to 1 gives a one-cycle `retry_start_o` and state 6. A later `tx_done` returns the state to 4.
- R6: A 1-to-0 change of bit 1 in states 0, 1, 4 or 6 has no effect on the state. A write that leaves bit 1 unchanged triggers nothing.
- R7: In state 0, a 0-to-1 change of bit 1 enters state 5. A 1-to-0 change in state 5 returns to state 0.
- R8: In state 2 or 3, a 0-to-1 change of bit 1 enters state 7. A 1-to-0 change in state 7 returns to whichever of 2 or 3 preceded it.
- R9: A command with `cmd_valid` high and a target in {0,1,2,3,4} is taken in states 0 to 4. Commands are ignored in states 5, 6 and 7, and commands with targets 5, 6 or 7 are ignored in every state.
- R10: A reset request forces state 0 on the same edge and overrides any level-bit action or command in that cycle. No start pulse is produced.
- R11: A level-bit action wins over a command in the same cycle. `tx_done` has no effect outside state 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | REG_W | Write data: bit 0 reset request, bit 1 level bit |
| rdata | output | REG_W | Register readback |
| cmd_valid | input | 1 | State-change command strobe |
| cmd_state | input | 3 | Requested steady state code |
| tx_done | input | 1 | End of the current transmission |
| state_o | output | 3 | Current sequencer state |
| tx_start_o | output | 1 | One-cycle basic transmit launch |
| retry_start_o | output | 1 | One-cycle auto-retry transmit launch |
| trx_reset_o | output | 1 | One-cycle sequencer reset strobe |

## Verification
The assertions assume that `tx_done` is meaningful only while a transmission is in flight. They also assume that the level bit changes only through register writes, so that the paused and doze states always coincide with a high level bit. Stimulus draws writes, commands and `tx_done` independently from a seeded generator, including illegal command codes and `tx_done` in every state. It keeps reset requests rare so that long sleep, pause and send sequences still occur. A bench model built from the requirements predicts every output on every cycle.

// File: rtl/trxc_pkg.sv
package trxc_pkg;

   localparam int unsigned STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      S_OFF         = 3'd0,
      S_READY       = 3'd1,
      S_LISTEN      = 3'd2,
      S_LISTEN_ACK  = 3'd3,
      S_READY_RETRY = 3'd4,
      S_DOZE        = 3'd5,
      S_SENDING     = 3'd6,
      S_PAUSED      = 3'd7
   } trxc_state_e;

   function automatic logic is_steady(input logic [STATE_W-1:0] code);
      return (code <= 3'd4);
   endfunction

endpackage

// File: rtl/trxc_ctrl_reg.sv
module trxc_ctrl_reg #(
   parameter int unsigned REG_W   = 2,
   parameter int unsigned RST_POS = 0,
   parameter int unsigned LVL_POS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic             lvl_o,
   output logic             rise_o,
   output logic             fall_o,
   output logic             rst_req_o,
   output logic             strobe_o,
   output logic [REG_W-1:0] rdata_o
);

   if (REG_W < 2) begin : g_bad_width
      $error("trxc_ctrl_reg: REG_W must be at least 2");
   end
   if (RST_POS == LVL_POS) begin : g_bad_pos
      $error("trxc_ctrl_reg: reset and level bits must differ");
   end
   if (RST_POS >= REG_W || LVL_POS >= REG_W) begin : g_bad_range
      $error("trxc_ctrl_reg: bit position outside register");
   end

   logic lvl_q;
   logic strobe_q;
   logic new_lvl;

   assign new_lvl   = wr_data[LVL_POS];
   assign rst_req_o = wr_en & wr_data[RST_POS];
   assign rise_o    = wr_en &  new_lvl & ~lvl_q;
   assign fall_o    = wr_en & ~new_lvl &  lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= 1'b0;
         strobe_q <= 1'b0;
      end else begin
         strobe_q <= rst_req_o;
         if (wr_en) lvl_q <= new_lvl;
      end
   end

   assign lvl_o    = lvl_q;
   assign strobe_o = strobe_q;

   for (genvar i = 0; i < REG_W; i++) begin : g_rd
      if (i == LVL_POS) begin : g_lvl
         assign rdata_o[i] = lvl_q;
      end else begin : g_zero
         assign rdata_o[i] = 1'b0;
      end
   end

   // R3: the level bit only moves on a write
   a_r3_level_held: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(lvl_q));

   // R2: the strobe lasts one cycle unless a new request arrives
   a_r2_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_q && !rst_req_o) |=> !strobe_q);

endmodule

// File: rtl/trxc_seq.sv
module trxc_seq
   import trxc_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               rst_req,
   input  logic               rise,
   input  logic               fall,
   input  logic               lvl,
   input  logic               cmd_valid,
   input  logic [STATE_W-1:0] cmd_state,
   input  logic               tx_done,
   output logic [STATE_W-1:0] state_o,
   output logic               basic_go_o,
   output logic               retry_go_o
);

   trxc_state_e st_q, st_n, ret_q, ret_n;
   logic        go_b_q, go_b_n, go_r_q, go_r_n;
   logic        cmd_ok;

   assign cmd_ok = cmd_valid & is_steady(cmd_state);

   always_comb begin
      st_n   = st_q;
      ret_n  = ret_q;
      go_b_n = 1'b0;
      go_r_n = 1'b0;
      if (rst_req) begin
         st_n  = S_OFF;
         ret_n = S_OFF;
      end else begin
         unique case (st_q)
            S_OFF: begin
               if (rise) begin
                  st_n  = S_DOZE;
                  ret_n = S_OFF;
               end else if (cmd_ok) st_n = trxc_state_e'(cmd_state);
            end
            S_READY, S_READY_RETRY: begin
               if (rise) begin
                  st_n  = S_SENDING;
                  ret_n = st_q;
                  if (st_q == S_READY) go_b_n = 1'b1;
                  else                 go_r_n = 1'b1;
               end else if (cmd_ok) st_n = trxc_state_e'(cmd_state);
            end
            S_LISTEN, S_LISTEN_ACK: begin
               if (rise) begin
                  st_n  = S_PAUSED;
                  ret_n = st_q;
               end else if (cmd_ok) st_n = trxc_state_e'(cmd_state);
            end
            S_DOZE, S_PAUSED: begin
               if (fall) st_n = ret_q;
            end
            S_SENDING: begin
               if (tx_done) st_n = ret_q;
            end
            default: st_n = S_OFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_OFF;
         ret_q  <= S_OFF;
         go_b_q <= 1'b0;
         go_r_q <= 1'b0;
      end else begin
         st_q   <= st_n;
         ret_q  <= ret_n;
         go_b_q <= go_b_n;
         go_r_q <= go_r_n;
      end
   end

   assign state_o    = st_q;
   assign basic_go_o = go_b_q;
   assign retry_go_o = go_r_q;

   // R7: doze is reached only from off
   a_r7_doze_from_off: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_q == S_DOZE) |-> $past(st_q) == S_OFF);

   // R8: paused and doze only while the level bit stays high
   a_r8_hold_needs_level: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == S_PAUSED || st_q == S_DOZE) |-> lvl);

   // R8: pause returns to a listen state
   a_r8_pause_return: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(st_q == S_PAUSED) |-> (st_q == S_LISTEN || st_q == S_LISTEN_ACK || st_q == S_OFF));

   // R4: basic launch is a single cycle
   a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
      go_b_q |=> !go_b_q);

   // R5: retry launch lands in sending
   a_r5_retry_sending: assert property (@(posedge clk) disable iff (!rst_n)
      go_r_q |-> st_q == S_SENDING);

endmodule

// File: rtl/trxc_ctrl.sv
module trxc_ctrl
   import trxc_pkg::*;
#(
   parameter int unsigned REG_W   = 2,
   parameter int unsigned RST_POS = 0,
   parameter int unsigned LVL_POS = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [REG_W-1:0]   wr_data,
   output logic [REG_W-1:0]   rdata,
   input  logic               cmd_valid,
   input  logic [STATE_W-1:0] cmd_state,
   input  logic               tx_done,
   output logic [STATE_W-1:0] state_o,
   output logic               tx_start_o,
   output logic               retry_start_o,
   output logic               trx_reset_o
);

   logic lvl, rise, fall, rst_req;

   trxc_ctrl_reg #(
      .REG_W  (REG_W),
      .RST_POS(RST_POS),
      .LVL_POS(LVL_POS)
   ) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .lvl_o    (lvl),
      .rise_o   (rise),
      .fall_o   (fall),
      .rst_req_o(rst_req),
      .strobe_o (trx_reset_o),
      .rdata_o  (rdata)
   );

   trxc_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .rst_req   (rst_req),
      .rise      (rise),
      .fall      (fall),
      .lvl       (lvl),
      .cmd_valid (cmd_valid),
      .cmd_state (cmd_state),
      .tx_done   (tx_done),
      .state_o   (state_o),
      .basic_go_o(tx_start_o),
      .retry_go_o(retry_start_o)
   );

   // R10: a reset strobe always coincides with the off state and no launch
   a_r10_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      trx_reset_o |-> (state_o == S_OFF && !tx_start_o && !retry_start_o));

   // R2: reset bit never reads back as one
   a_r2_readback_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rdata[RST_POS] == 1'b0);

endmodule

// File: tb/trxc_ctrl_tb.sv
module trxc_ctrl_tb;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_data = '0;
   logic [1:0] rdata;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_state = '0;
   logic       tx_done = 1'b0;
   logic [2:0] state_o;
   logic       tx_start_o, retry_start_o, trx_reset_o;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   logic [2:0] m_st = 3'd0, m_ret = 3'd0;
   logic       m_lvl = 1'b0;

   always #10 clk = ~clk;

   trxc_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rdata(rdata),
      .cmd_valid(cmd_valid), .cmd_state(cmd_state), .tx_done(tx_done),
      .state_o(state_o), .tx_start_o(tx_start_o), .retry_start_o(retry_start_o),
      .trx_reset_o(trx_reset_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // expected sequencer step derived from the requirements
   task automatic step(input string tag, input logic we, input logic [1:0] wd,
                       input logic cv, input logic [2:0] cs, input logic dn);
      logic rise, fall, eb, er, es;
      logic [2:0] ns, nr;
      rise = we & wd[1] & ~m_lvl;
      fall = we & ~wd[1] & m_lvl;
      es = we & wd[0];
      eb = 1'b0; er = 1'b0;
      ns = m_st; nr = m_ret;
      if (es) begin
         ns = 3'd0; nr = 3'd0;
      end else begin
         case (m_st)
            3'd0, 3'd1, 3'd2, 3'd3, 3'd4: begin
               if (rise) begin
                  nr = m_st;
                  case (m_st)
                     3'd0: ns = 3'd5;
                     3'd1: begin ns = 3'd6; eb = 1'b1; end
                     3'd4: begin ns = 3'd6; er = 1'b1; end
                     default: ns = 3'd7;
                  endcase
               end else if (cv && cs <= 3'd4) ns = cs;
            end
            3'd5, 3'd7: if (fall) ns = m_ret;
            default: if (dn) ns = m_ret;
         endcase
      end
      if (we) m_lvl = wd[1];
      m_st = ns; m_ret = nr;
      @(negedge clk);
      wr_en = we; wr_data = wd; cmd_valid = cv; cmd_state = cs; tx_done = dn;
      @(posedge clk);
      #1;
      chk({tag, " state"}, state_o, ns);
      chk({tag, " tx_start"}, tx_start_o, eb);
      chk({tag, " retry_start"}, retry_start_o, er);
      chk({tag, " reset strobe"}, trx_reset_o, es);
      chk({tag, " rdata"}, rdata, {m_lvl, 1'b0});
      @(negedge clk);
      wr_en = 1'b0; cmd_valid = 1'b0; tx_done = 1'b0;
   endtask

   task automatic idle(input string tag);
      step(tag, 1'b0, 2'b00, 1'b0, 3'd0, 1'b0);
   endtask

   initial begin
      #4000000;
      if (!finished) begin
         n_run++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1234;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1;
      chk("R1 reset state", state_o, 0);
      chk("R1 reset pulses", {tx_start_o, retry_start_o, trx_reset_o}, 0);
      chk("R1 reset rdata", rdata, 0);
      @(negedge clk); rst_n = 1'b1;
      idle("R1 after release");

      step("R9 cmd ready", 0, 2'b00, 1, 3'd1, 0);
      step("R4 launch", 1, 2'b10, 0, 3'd0, 0);
      idle("R4 pulse ends");
      step("R6 fall in sending", 1, 2'b00, 0, 3'd0, 0);
      step("R9 cmd in sending", 0, 2'b00, 1, 3'd2, 0);
      step("R4 done", 0, 2'b00, 0, 3'd0, 1);
      step("R9 cmd retry", 0, 2'b00, 1, 3'd4, 0);
      step("R5 launch", 1, 2'b10, 0, 3'd0, 0);
      step("R5 done", 0, 2'b00, 0, 3'd0, 1);
      step("R6 fall in retry", 1, 2'b00, 0, 3'd0, 0);
      step("R6 same value", 1, 2'b00, 0, 3'd0, 0);
      step("R9 cmd off", 0, 2'b00, 1, 3'd0, 0);
      step("R7 doze", 1, 2'b10, 0, 3'd0, 0);
      step("R3 level held", 1, 2'b10, 0, 3'd0, 0);
      step("R9 cmd in doze", 0, 2'b00, 1, 3'd1, 0);
      step("R7 wake", 1, 2'b00, 0, 3'd0, 0);
      step("R9 cmd listen", 0, 2'b00, 1, 3'd2, 0);
      step("R8 pause", 1, 2'b10, 0, 3'd0, 0);
      step("R8 resume", 1, 2'b00, 0, 3'd0, 0);
      step("R9 cmd listen ack", 0, 2'b00, 1, 3'd3, 0);
      step("R8 pause ack", 1, 2'b10, 0, 3'd0, 0);
      step("R11 done ignored", 0, 2'b00, 0, 3'd0, 1);
      step("R8 resume ack", 1, 2'b00, 0, 3'd0, 0);
      step("R9 illegal target", 0, 2'b00, 1, 3'd6, 0);
      step("R9 cmd ready2", 0, 2'b00, 1, 3'd1, 0);
      step("R10 reset beats launch", 1, 2'b11, 0, 3'd0, 0);
      step("R2 strobe ends", 0, 2'b00, 0, 3'd0, 0);
      step("R6 fall in off", 1, 2'b00, 0, 3'd0, 0);
      step("R9 cmd ready3", 0, 2'b00, 1, 3'd1, 0);
      step("R11 launch beats cmd", 1, 2'b10, 1, 3'd2, 0);
      step("R2 reset in sending", 1, 2'b01, 0, 3'd0, 0);

      for (int i = 0; i < 4000; i++) begin
         logic we, cv, dn;
         logic [1:0] wd;
         we = ($urandom % 3) == 0;
         wd[1] = $urandom % 2;
         wd[0] = ($urandom % 20) == 0;
         cv = ($urandom % 4) == 0;
         dn = ($urandom % 5) == 0;
         step("R9 random", we, wd, cv, 3'($urandom % 8), dn);
      end

      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule